// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block pairs a free-running 16-bit up-counter with a 16-bit compare register. On every clock where the counter equals the compare value, the block carries out the action of the selected mode. It can drive a compare pin high or low, or raise a sticky compare flag and nothing else. In event mode it restarts the counter from zero and emits one-cycle pulses. One pulse reports the counter restart and the other asks an external converter to begin a conversion.

Software programs a 4-bit mode code and the compare value through two write strobes. It clears the two sticky flags with write-one-to-clear inputs. A sleep input freezes the whole unit and the pin keeps its level. Event mode turns the compare value into a counter period of compare+1 cycles. Such a restart is never reported as a counter overflow.

Top module: `cmp_event_unit`

## Requirements
- R1: After a synchronous reset the mode is off, the compare value is 0, the counter is 0, and the pin, both flags and both pulses are low.
- R2: While sleep is low and no event restart occurs, the counter steps by one per clock and wraps from 0xFFFF to 0x0000.
- R3: The overflow flag is set on the edge where the counter wraps from 0xFFFF through normal counting. It stays set until a cycle with ovf_flag_clr high, and a set in the same cycle wins over the clear.
- R4: Writing mode 1000 (drive high on match) forces the pin low at that edge, and a match later drives it high. Writing mode 1001 (drive low on match) forces the pin high at that edge, and a match later drives it low.
- R5: A match is the counter equal to the compare value at a clock edge with sleep low, in any of the modes 1000, 1001, 1010 and 1011. A match sets the compare flag, which stays set until a cycle with cmp_flag_clr high; a set wins over a clear.
- R6: In mode 1010 (flag only) a match leaves the pin unchanged.
- R7: In mode 1011 (event) a match loads the counter with 0 instead of incrementing it. It also raises tmr_reset_pulse for exactly the following cycle, so the period is compare+1 cycles.
- R8: An event-mode match raises conv_start_pulse for the following cycle only when adc_enabled is high at the match edge.
- R9: An event-mode restart never sets the overflow flag, even with a compare value of 0xFFFF.
- R10: While sleep is high the counter, mode, compare value, pin and flags hold, writes and flag clears are ignored, and both pulses are low.
- R11: Writing mode 0000 forces the pin low. Codes outside 0000, 1000, 1001, 1010 and 1011 leave the pin unchanged and no match takes place under them.
- R12: A mode write at a match edge lets the old mode decide the match (flag, counter restart, pulses). A forced pin level from the new mode overrides the old mode's pin action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Freezes all state while high |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | Mode code to write |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | TMR_W | Compare value to write |
| adc_enabled | input | 1 | Converter enabled; gates conversion start |
| cmp_flag_clr | input | 1 | Write-one-to-clear for the compare flag |
| ovf_flag_clr | input | 1 | Write-one-to-clear for the overflow flag |
| cmp_pin | output | 1 | Compare output latch |
| cmp_flag | output | 1 | Sticky compare interrupt flag |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| tmr_reset_pulse | output | 1 | One-cycle pulse after an event restart |
| conv_start_pulse | output | 1 | One-cycle conversion start request |
| tmr_count | output | TMR_W | Current counter value |

## Verification
Every result is registered, so the effect of an edge is visible one cycle later. Writes, forced pin levels, counter restarts, flag sets and clears, and both pulses all appear in the cycle after the edge that caused them. A match is decided on the counter value shown before that edge. The bench drives inputs on the falling edge and updates its arithmetic expectation at the rising edge from the values applied before it. It compares every output on the next falling edge. Scenario checks step the counter to the compare value first and then sample after exactly one further edge, which covers collisions of writes with matches, sleep windows and full counter wraps.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF     = 4'b0000,
        MODE_SET_HI  = 4'b1000,
        MODE_CLR_LO  = 4'b1001,
        MODE_IRQ     = 4'b1010,
        MODE_EVENT   = 4'b1011
    } cmp_mode_e;

    // Decoded per-mode match behaviour
    typedef struct packed {
        logic active;    // a match is acted upon
        logic drive_hi;  // match drives pin high
        logic drive_lo;  // match drives pin low
        logic period;    // match restarts the counter
    } mode_dec_t;

    // Pin level forced at the moment a mode is written
    typedef struct packed {
        logic has_level;
        logic level;
    } entry_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d = '0;
        case (m)
            MODE_SET_HI: begin d.active = 1'b1; d.drive_hi = 1'b1; end
            MODE_CLR_LO: begin d.active = 1'b1; d.drive_lo = 1'b1; end
            MODE_IRQ:    begin d.active = 1'b1; end
            MODE_EVENT:  begin d.active = 1'b1; d.period = 1'b1; end
            default:     d = '0;
        endcase
        return d;
    endfunction

    function automatic entry_t entry_level(input logic [MODE_W-1:0] m);
        entry_t e;
        e = '0;
        case (m)
            MODE_OFF:    begin e.has_level = 1'b1; e.level = 1'b0; end
            MODE_SET_HI: begin e.has_level = 1'b1; e.level = 1'b0; end
            MODE_CLR_LO: begin e.has_level = 1'b1; e.level = 1'b1; end
            default:     e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clr_req,
    input  logic         ovf_clr,
    output logic [W-1:0] tmr_q,
    output logic         ovf_q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic wrap;
    assign wrap = run && !clr_req && (tmr_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
            ovf_q <= 1'b0;
        end else if (run) begin
            tmr_q <= clr_req ? '0 : tmr_q + 1'b1;
            if (wrap)
                ovf_q <= 1'b1;
            else if (ovf_clr)
                ovf_q <= 1'b0;
        end
    end

    assert_count_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !clr_req) |=> (tmr_q == $past(tmr_q) + 1'b1));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (run && clr_req) |=> (tmr_q == '0));

    assert_ovf_only_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> ($past(tmr_q) == TOP && !$past(clr_req)));

    assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(tmr_q) && $stable(ovf_q)));

endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cmp_wr,
    input  logic [W-1:0]      cmp_wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic [W-1:0]      cmp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            cmp_q  <= '0;
        end else if (run) begin
            if (mode_wr) mode_q <= mode_wdata;
            if (cmp_wr)  cmp_q  <= cmp_wdata;
        end
    end

    assert_regs_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(mode_q) && $stable(cmp_q)));

endmodule

// File: rtl/cmp_match_ctrl.sv
module cmp_match_ctrl
    import cmp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [W-1:0]      tmr_q,
    input  logic [W-1:0]      cmp_q,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              adc_en,
    input  logic              flag_clr,
    output logic              clr_req,
    output logic              pin_q,
    output logic              flag_q,
    output logic              rst_pulse_q,
    output logic              conv_pulse_q
);
    mode_dec_t dec;
    entry_t    ent;
    logic      hit;

    assign dec     = decode_mode(mode_q);
    assign ent     = entry_level(mode_wdata);
    assign hit     = run && dec.active && (tmr_q == cmp_q);
    assign clr_req = hit && dec.period;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q        <= 1'b0;
            flag_q       <= 1'b0;
            rst_pulse_q  <= 1'b0;
            conv_pulse_q <= 1'b0;
        end else if (run) begin
            if (mode_wr && ent.has_level)
                pin_q <= ent.level;
            else if (hit && dec.drive_hi)
                pin_q <= 1'b1;
            else if (hit && dec.drive_lo)
                pin_q <= 1'b0;

            if (hit)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;

            rst_pulse_q  <= clr_req;
            conv_pulse_q <= clr_req && adc_en;
        end else begin
            rst_pulse_q  <= 1'b0;
            conv_pulse_q <= 1'b0;
        end
    end

    assert_flag_on_match_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(tmr_q == cmp_q));

    assert_irq_pin_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IRQ && $past(mode_q) == MODE_IRQ) |-> $stable(pin_q));

    assert_conv_with_restart_R8: assert property (@(posedge clk) disable iff (rst)
        conv_pulse_q |-> rst_pulse_q);

    assert_no_pulse_after_sleep_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!run) |-> (!rst_pulse_q && !conv_pulse_q));

    assert_off_pin_low_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF) |-> !pin_q);

endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
    import cmp_pkg::*;
#(
    parameter int unsigned TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep,
    input  logic             mode_wr,
    input  logic [3:0]       mode_wdata,
    input  logic             cmp_wr,
    input  logic [TMR_W-1:0] cmp_wdata,
    input  logic             adc_enabled,
    input  logic             cmp_flag_clr,
    input  logic             ovf_flag_clr,
    output logic             cmp_pin,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             tmr_reset_pulse,
    output logic             conv_start_pulse,
    output logic [TMR_W-1:0] tmr_count
);
    logic              run;
    logic              clr_req;
    logic [MODE_W-1:0] mode_q;
    logic [TMR_W-1:0]  cmp_q;

    assign run = !sleep;

    cmp_regs #(.W(TMR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .mode_q     (mode_q),
        .cmp_q      (cmp_q)
    );

    cmp_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .clr_req (clr_req),
        .ovf_clr (ovf_flag_clr),
        .tmr_q   (tmr_count),
        .ovf_q   (ovf_flag)
    );

    cmp_match_ctrl #(.W(TMR_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .tmr_q        (tmr_count),
        .cmp_q        (cmp_q),
        .mode_q       (mode_q),
        .mode_wr      (mode_wr),
        .mode_wdata   (mode_wdata),
        .adc_en       (adc_enabled),
        .flag_clr     (cmp_flag_clr),
        .clr_req      (clr_req),
        .pin_q        (cmp_pin),
        .flag_q       (cmp_flag),
        .rst_pulse_q  (tmr_reset_pulse),
        .conv_pulse_q (conv_start_pulse)
    );

endmodule

// File: tb/sim_cmp_event_unit.sv
`timescale 1ns/1ps
module sim_cmp_event_unit;

    logic        clk = 1'b0;
    logic        b_rst = 1'b1;
    logic        b_sleep = 1'b0;
    logic        b_mode_wr = 1'b0;
    logic [3:0]  b_mode_d = 4'b0;
    logic        b_cmp_wr = 1'b0;
    logic [15:0] b_cmp_d = 16'h0;
    logic        b_adc = 1'b0;
    logic        b_flag_clr = 1'b0;
    logic        b_ovf_clr = 1'b0;

    logic        cmp_pin, cmp_flag, ovf_flag, tmr_reset_pulse, conv_start_pulse;
    logic [15:0] tmr_count;

    // expectation state
    logic [15:0] m_tmr = 16'h0, m_cmp = 16'h0;
    logic [3:0]  m_mode = 4'b0;
    logic        m_pin = 1'b0, m_flag = 1'b0, m_ovf = 1'b0, m_rp = 1'b0, m_cp = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmp_event_unit u0 (
        .clk              (clk),
        .rst              (b_rst),
        .sleep            (b_sleep),
        .mode_wr          (b_mode_wr),
        .mode_wdata       (b_mode_d),
        .cmp_wr           (b_cmp_wr),
        .cmp_wdata        (b_cmp_d),
        .adc_enabled      (b_adc),
        .cmp_flag_clr     (b_flag_clr),
        .ovf_flag_clr     (b_ovf_clr),
        .cmp_pin          (cmp_pin),
        .cmp_flag         (cmp_flag),
        .ovf_flag         (ovf_flag),
        .tmr_reset_pulse  (tmr_reset_pulse),
        .conv_start_pulse (conv_start_pulse),
        .tmr_count        (tmr_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic is_active(input logic [3:0] m);
        return (m == 4'b1000) || (m == 4'b1001) || (m == 4'b1010) || (m == 4'b1011);
    endfunction

    // One clock: expectation follows the requirements, outputs checked at negedge
    task automatic step();
        logic hit, spec;
        @(posedge clk);
        if (b_rst) begin
            m_tmr = 0; m_cmp = 0; m_mode = 0;
            m_pin = 0; m_flag = 0; m_ovf = 0; m_rp = 0; m_cp = 0;
        end else if (!b_sleep) begin
            hit  = is_active(m_mode) && (m_tmr == m_cmp);
            spec = hit && (m_mode == 4'b1011);
            if (!spec && m_tmr == 16'hFFFF) m_ovf = 1'b1;
            else if (b_ovf_clr) m_ovf = 1'b0;
            m_tmr = spec ? 16'h0 : m_tmr + 16'h1;
            if (hit) m_flag = 1'b1;
            else if (b_flag_clr) m_flag = 1'b0;
            if (b_mode_wr && b_mode_d == 4'b1000) m_pin = 1'b0;
            else if (b_mode_wr && b_mode_d == 4'b1001) m_pin = 1'b1;
            else if (b_mode_wr && b_mode_d == 4'b0000) m_pin = 1'b0;
            else if (hit && m_mode == 4'b1000) m_pin = 1'b1;
            else if (hit && m_mode == 4'b1001) m_pin = 1'b0;
            m_rp = spec;
            m_cp = spec && b_adc;
            if (b_mode_wr) m_mode = b_mode_d;
            if (b_cmp_wr) m_cmp = b_cmp_d;
        end else begin
            m_rp = 1'b0;
            m_cp = 1'b0;
        end
        @(negedge clk);
        b_mode_wr = 0; b_cmp_wr = 0; b_flag_clr = 0; b_ovf_clr = 0;
        check("R2 counter", 32'(tmr_count), 32'(m_tmr));
        check("R4 pin", 32'(cmp_pin), 32'(m_pin));
        check("R5 cmp flag", 32'(cmp_flag), 32'(m_flag));
        check("R3 ovf flag", 32'(ovf_flag), 32'(m_ovf));
        check("R7 reset pulse", 32'(tmr_reset_pulse), 32'(m_rp));
        check("R8 conv pulse", 32'(conv_start_pulse), 32'(m_cp));
    endtask

    task automatic do_reset();
        b_rst = 1'b1;
        step();
        step();
        b_rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] md, input logic [15:0] cv, input logic wm, input logic wc);
        b_mode_wr = wm; b_mode_d = md;
        b_cmp_wr = wc;  b_cmp_d = cv;
    endtask

    task automatic run_to(input logic [15:0] v);
        while (m_tmr != v) step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R2: actual hung expected finish");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 pin", 32'(cmp_pin), 0);
        check("R1 flags", {30'b0, cmp_flag, ovf_flag}, 0);
        check("R1 pulses", {30'b0, tmr_reset_pulse, conv_start_pulse}, 0);
        check("R1 counter", 32'(tmr_count), 0);

        // R4 clear-on-match entry forces high, match drives low
        wr(4'b1001, 16'd20, 1, 1); step();
        check("R4 entry high", 32'(cmp_pin), 1);
        run_to(16'd20); step();
        check("R4 match low", 32'(cmp_pin), 0);
        check("R5 flag set", 32'(cmp_flag), 1);
        b_flag_clr = 1; step();
        check("R5 flag cleared", 32'(cmp_flag), 0);

        // R4 set-on-match entry forces low, match drives high
        wr(4'b1000, 16'd40, 1, 1); step();
        check("R4 entry low", 32'(cmp_pin), 0);
        run_to(16'd40); step();
        check("R4 match high", 32'(cmp_pin), 1);

        // R10 sleep freezes state and ignores writes and clears
        begin
            logic [15:0] t;
            t = m_tmr;
            b_sleep = 1;
            for (int i = 0; i < 10; i++) begin
                wr(4'b0000, 16'd5, 1, 1); b_flag_clr = 1; b_ovf_clr = 1;
                step();
                check("R10 counter held", 32'(tmr_count), 32'(t));
                check("R10 pin held", 32'(cmp_pin), 1);
                check("R10 flag held", 32'(cmp_flag), 1);
            end
            b_sleep = 0; step();
            check("R10 resume", 32'(tmr_count), 32'(t + 16'd1));
        end

        // R6 flag-only mode leaves pin alone
        wr(4'b1010, m_tmr + 16'd6, 1, 1); b_flag_clr = 1; step();
        run_to(m_cmp); step();
        check("R6 pin unchanged", 32'(cmp_pin), 1);
        check("R5 flag irq mode", 32'(cmp_flag), 1);

        // R11 off forces low, unlisted code keeps pin and never matches
        wr(4'b1001, 0, 1, 0); step();
        wr(4'b0000, 0, 1, 0); step();
        check("R11 off low", 32'(cmp_pin), 0);
        wr(4'b1001, 0, 1, 0); step();
        check("R4 high again", 32'(cmp_pin), 1);
        wr(4'b1100, m_tmr + 16'd3, 1, 1); b_flag_clr = 1; step();
        check("R11 unlisted keeps pin", 32'(cmp_pin), 1);
        run_to(m_cmp); step(); step();
        check("R11 no match flag", 32'(cmp_flag), 0);
        check("R11 no match pin", 32'(cmp_pin), 1);

        // R12 mode write colliding with a match
        wr(4'b1000, m_tmr + 16'd4, 1, 1); step();
        run_to(m_cmp);
        wr(4'b0000, 0, 1, 0); step();
        check("R12 forced low wins", 32'(cmp_pin), 0);
        check("R12 old mode flag", 32'(cmp_flag), 1);
        wr(4'b1011, m_tmr + 16'd4, 1, 1); step();
        run_to(m_cmp);
        wr(4'b0000, 0, 1, 0); step();
        check("R12 old mode restart", 32'(tmr_count), 0);
        check("R12 old mode pulse", 32'(tmr_reset_pulse), 1);

        // R7/R8 event period sweep
        for (int p = 2; p < 10; p++) begin
            for (int a = 0; a < 2; a++) begin
                int nr, nc;
                do_reset();
                b_adc = a[0];
                wr(4'b1011, 16'(p), 1, 1); step();
                nr = 0; nc = 0;
                for (int k = 0; k < 4 * (p + 1); k++) begin
                    step();
                    nr += int'(tmr_reset_pulse);
                    nc += int'(conv_start_pulse);
                end
                check("R7 restart count", 32'(nr), 4);
                check("R8 conv count", 32'(nc), 32'(4 * a));
            end
        end
        b_adc = 1;

        // R4 pin mode sweep over compare values
        for (int p = 2; p < 10; p++) begin
            for (int md = 0; md < 2; md++) begin
                do_reset();
                wr(md[0] ? 4'b1001 : 4'b1000, 16'(p), 1, 1); step();
                run_to(16'(p)); step();
                check("R4 sweep pin", 32'(cmp_pin), md[0] ? 0 : 1);
            end
        end

        // R3 overflow by counting
        do_reset();
        wr(4'b1000, 16'h1234, 1, 1); step();
        run_to(16'hFFFF); step();
        check("R3 ovf set", 32'(ovf_flag), 1);
        check("R2 wrap", 32'(tmr_count), 0);
        b_ovf_clr = 1; step();
        check("R3 ovf cleared", 32'(ovf_flag), 0);

        // R9 event restart at 0xFFFF is not an overflow
        wr(4'b1011, 16'hFFFF, 1, 1); step();
        run_to(16'hFFFF); step();
        check("R9 restart to zero", 32'(tmr_count), 0);
        check("R9 no ovf", 32'(ovf_flag), 0);
        check("R7 pulse at FFFF", 32'(tmr_reset_pulse), 1);
        step();
        check("R7 pulse one cycle", 32'(tmr_reset_pulse), 0);

        summary();
    end

endmodule